// File: doc/BRIEF.md
# Six-Channel Up-Counting Event Timer Bank

The block holds a bank of six 32-bit timers that count upward. Software reaches them over a small register bus with address, write data, write strobe, read strobe and read data. Each timer has four registers: control, clock select, count and compare. In each clock cycle a timer advances on one of two tick-enable inputs. One input stands in for a fast system reference and the other for a slow 32 kHz reference. The advance can optionally happen on every second tick instead of every tick.

A timer runs in one of three modes. A one-shot timer stops when it reaches its compare value. A repeating timer restarts from zero, which gives a period equal to the compare value. A free-running timer serves as a plain 32-bit timebase and raises no events. A compare match sets a pending flag for that timer. Two shared registers hold one interrupt-enable bit and one write-one-to-clear acknowledge bit per timer. A single interrupt line is asserted while any enabled timer has its flag pending.

Top module: `gpTimerBank`

## Requirements
- R1: After reset every register reads as zero and irqOut is low.
- R2: Register addresses and read timing:
  - The interrupt-enable register is at 0x00 and the pending/acknowledge register is at 0x08. Timer n (1..6) uses bit n-1 in both.
  - Timer n has control at 0x10*n, clock select at 0x10*n+0x04, count at 0x10*n+0x08 and compare at 0x10*n+0x0C.
  - Read data appears on the cycle after a read strobe and holds until the next read strobe.
- R3: Control register fields:
  - Bit 0 enables counting.
  - Bits [5:4] set the mode: 0 one-shot, 1 repeat, 3 free-run. Code 2 behaves as free-run.
  - Writing 1 to bit 1 zeroes the count and the divider phase in that same write, which may also set the enable bit. Bit 1 always reads back as 0.
- R4: While enabled, the count rises by one for each selected tick. Clearing the enable bit freezes the count at its current value.
- R5: Clock-select register fields:
  - Bit 4 chooses the tick: 0 selects fastTick, 1 selects slowTick.
  - Bit 0 chooses the divider: 0 advances on every tick, 1 advances on every second tick.
- R6: In one-shot mode, the tick that brings the count to the compare value sets the pending flag, clears the enable bit and leaves the count equal to the compare value.
- R7: In repeat mode, the tick that brings the count to the compare value sets the pending flag and returns the count to zero. Counting then continues.
- R8: In free-run mode the pending flag is never set, and the count wraps from 0xFFFFFFFF to 0. A write to the count register loads the count.
- R9: Pending flags and acknowledge:
  - Reading 0x08 returns the pending flags.
  - Writing 1 to bit n-1 of 0x08 clears timer n's flag, and writing 0 leaves the flag unchanged.
  - A match in the same cycle as an acknowledge leaves the flag set.
- R10: irqOut is high exactly when some timer has both its pending flag and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, data valid next cycle |
| busRdata | output | 32 | Registered read data |
| fastTick | input | 1 | Fast reference tick enable |
| slowTick | input | 1 | Slow reference tick enable |
| irqOut | output | 1 | Combined interrupt |

## Verification
The checker watches several properties on every cycle:
- a free-running timer's flag never rises;
- a one-shot timer has cleared its own enable by the cycle its flag rises;
- irqOut never stands without some pending flag;
- read data holds between read strobes;
- the clear bit never reads back.

Other behaviour can only be shown by the bench's scenarios: count values after given tick runs, divider phase after a clear, source selection, wrap-around, repeat reload, acknowledge masking, and the set-over-acknowledge race. Random programs of mode, divider, compare value and tick count are compared against closed-form expected counts and flags.

// File: rtl/gpTimerPkg.sv
package gpTimerPkg;
  localparam int IRQ_EN_OFF = 'h00;
  localparam int IRQ_ACK_OFF = 'h08;

  localparam logic [1:0] MODE_ONCE = 2'd0;
  localparam logic [1:0] MODE_RPT  = 2'd1;
  localparam logic [1:0] MODE_FREE = 2'd3;

  // per-channel strobes from register decode to datapath
  typedef struct packed {
    logic ctrlWr;
    logic clkWr;
    logic cntWr;
    logic cmpWr;
    logic ackHit;
  } chanStb_t;
endpackage

// File: rtl/timerCtrl.sv
module timerCtrl
  import gpTimerPkg::*;
#(
  parameter int NUM = 6,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [AW-1:0]          busAddr,
  input  logic [NUM-1:0]         wdataLow,
  input  logic                   busWr,
  input  logic                   busRd,
  input  logic [NUM-1:0]         enVec,
  input  logic [NUM-1:0][1:0]    modeVec,
  input  logic [NUM-1:0]         srcVec,
  input  logic [NUM-1:0]         divVec,
  input  logic [NUM-1:0][DW-1:0] cntVec,
  input  logic [NUM-1:0][DW-1:0] cmpVec,
  input  logic [NUM-1:0]         pendingVec,
  output chanStb_t [NUM-1:0]     stb,
  output logic [NUM-1:0]         irqEnVec,
  output logic [DW-1:0]          busRdata,
  output logic                   irqOut
);
  localparam int SW = AW - 4;

  logic [SW-1:0] chanSel;
  logic [1:0]    regSel;
  logic          wordAlign;
  logic          enHit;
  logic          ackHit;
  logic [DW-1:0] rdNext;

  assign chanSel   = busAddr[AW-1:4];
  assign regSel    = busAddr[3:2];
  assign wordAlign = (busAddr[1:0] == 2'b00);
  assign enHit     = (busAddr == AW'(IRQ_EN_OFF));
  assign ackHit    = (busAddr == AW'(IRQ_ACK_OFF));

  for (genvar i = 0; i < NUM; i++) begin : g_stb
    logic hit;
    assign hit = busWr && wordAlign && (chanSel == SW'(i + 1));
    assign stb[i].ctrlWr = hit && (regSel == 2'd0);
    assign stb[i].clkWr  = hit && (regSel == 2'd1);
    assign stb[i].cntWr  = hit && (regSel == 2'd2);
    assign stb[i].cmpWr  = hit && (regSel == 2'd3);
    assign stb[i].ackHit = busWr && ackHit && wdataLow[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqEnVec <= '0;
    else if (busWr && enHit) irqEnVec <= wdataLow;
  end

  always_comb begin
    rdNext = '0;
    if (enHit) rdNext[NUM-1:0] = irqEnVec;
    else if (ackHit) rdNext[NUM-1:0] = pendingVec;
    for (int i = 0; i < NUM; i++) begin
      if (wordAlign && chanSel == SW'(i + 1)) begin
        case (regSel)
          2'd0: begin rdNext[0] = enVec[i]; rdNext[5:4] = modeVec[i]; end
          2'd1: begin rdNext[0] = divVec[i]; rdNext[4] = srcVec[i]; end
          2'd2: rdNext = cntVec[i];
          default: rdNext = cmpVec[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (busRd) busRdata <= rdNext;
  end

  assign irqOut = |(pendingVec & irqEnVec);
endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import gpTimerPkg::*;
#(
  parameter int NUM = 6,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  chanStb_t [NUM-1:0]     stb,
  input  logic [DW-1:0]          wdata,
  input  logic                   fastTick,
  input  logic                   slowTick,
  output logic [NUM-1:0]         enVec,
  output logic [NUM-1:0][1:0]    modeVec,
  output logic [NUM-1:0]         srcVec,
  output logic [NUM-1:0]         divVec,
  output logic [NUM-1:0][DW-1:0] cntVec,
  output logic [NUM-1:0][DW-1:0] cmpVec,
  output logic [NUM-1:0]         pendingVec
);
  for (genvar i = 0; i < NUM; i++) begin : g_chan
    logic          tick;
    logic          phase;
    logic [DW-1:0] nxtCnt;
    logic          matchMode;

    assign tick      = srcVec[i] ? slowTick : fastTick;
    assign nxtCnt    = cntVec[i] + DW'(1);
    assign matchMode = (modeVec[i] == MODE_ONCE) || (modeVec[i] == MODE_RPT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enVec[i]      <= 1'b0;
        modeVec[i]    <= MODE_ONCE;
        srcVec[i]     <= 1'b0;
        divVec[i]     <= 1'b0;
        cntVec[i]     <= '0;
        cmpVec[i]     <= '0;
        pendingVec[i] <= 1'b0;
        phase         <= 1'b0;
      end else begin
        if (stb[i].ackHit) pendingVec[i] <= 1'b0;
        if (stb[i].clkWr) begin
          srcVec[i] <= wdata[4];
          divVec[i] <= wdata[0];
        end
        if (stb[i].cmpWr) cmpVec[i] <= wdata;
        if (stb[i].ctrlWr) begin
          enVec[i]   <= wdata[0];
          modeVec[i] <= wdata[5:4];
          if (wdata[1]) begin
            cntVec[i] <= '0;
            phase     <= 1'b0;
          end
        end else if (stb[i].cntWr) begin
          cntVec[i] <= wdata;
        end else if (enVec[i] && tick) begin
          if (divVec[i] && !phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (matchMode && nxtCnt == cmpVec[i]) begin
              pendingVec[i] <= 1'b1;  // overrides a same-cycle acknowledge
              if (modeVec[i] == MODE_ONCE) begin
                enVec[i]  <= 1'b0;
                cntVec[i] <= nxtCnt;
              end else begin
                cntVec[i] <= '0;
              end
            end else begin
              cntVec[i] <= nxtCnt;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/gpTimerBank.sv
module gpTimerBank
  import gpTimerPkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  input  logic              fastTick,
  input  logic              slowTick,
  output logic              irqOut
);
  chanStb_t [NUM_TIMERS-1:0]         stb;
  logic [NUM_TIMERS-1:0]             enVec, srcVec, divVec, pendingVec, irqEnVec;
  logic [NUM_TIMERS-1:0][1:0]        modeVec;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] cntVec, cmpVec;

  timerCtrl #(.NUM(NUM_TIMERS), .DW(DATA_W), .AW(ADDR_W)) ctrlU (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wdataLow(busWdata[NUM_TIMERS-1:0]),
    .busWr(busWr), .busRd(busRd), .enVec(enVec), .modeVec(modeVec), .srcVec(srcVec),
    .divVec(divVec), .cntVec(cntVec), .cmpVec(cmpVec), .pendingVec(pendingVec),
    .stb(stb), .irqEnVec(irqEnVec), .busRdata(busRdata), .irqOut(irqOut)
  );

  timerDatapath #(.NUM(NUM_TIMERS), .DW(DATA_W)) dpU (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .fastTick(fastTick),
    .slowTick(slowTick), .enVec(enVec), .modeVec(modeVec), .srcVec(srcVec),
    .divVec(divVec), .cntVec(cntVec), .cmpVec(cmpVec), .pendingVec(pendingVec)
  );
endmodule

// File: rtl/gpTimerBankChk.sv
module gpTimerBankChk #(
  parameter int NUM = 6,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [AW-1:0]      busAddr,
  input logic               busRd,
  input logic [DW-1:0]      busRdata,
  input logic               irqOut,
  input logic [NUM-1:0]     pendingVec,
  input logic [NUM-1:0]     enVec,
  input logic [NUM-1:0][1:0] modeVec
);
  // R10
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|pendingVec));

  // R2
  read_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

  // R3
  clear_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[3:0] == 4'h0 && busAddr[AW-1:4] != '0) |=> !busRdata[1]);

  for (genvar i = 0; i < NUM; i++) begin : g_chk
    // R8
    free_run_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeVec[i] == 2'd3 && !pendingVec[i]) |=> !pendingVec[i]);

    // R6
    one_shot_self_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(pendingVec[i]) && modeVec[i] == 2'd0) |-> !enVec[i]);
  end
endmodule

bind gpTimerBank gpTimerBankChk #(.NUM(NUM_TIMERS), .DW(DATA_W), .AW(ADDR_W)) chk (.*);

// File: tb/gpTimerBank_test.sv
`timescale 1ns/1ps
module gpTimerBank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic        fastTick = 1'b0;
  logic        slowTick = 1'b0;
  logic        irqOut;
  int          checks = 0;
  int          errors = 0;

  gpTimerBank uut (.*);

  always #4 clk = ~clk;

  function automatic logic [7:0] regA(input int n, input int r);
    return 8'(16 * n + 4 * r);
  endfunction

  function automatic logic [31:0] expCount(input int mode, input int dv, input int cmp, input int n);
    int eff = dv ? n / 2 : n;
    if (mode == 0) return 32'((eff >= cmp) ? cmp : eff);
    if (mode == 1) return 32'(eff % cmp);
    return 32'(eff);
  endfunction

  function automatic logic expPend(input int mode, input int dv, input int cmp, input int n);
    int eff = dv ? n / 2 : n;
    return (mode != 3) && (eff >= cmp);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic ticks(input int n, input bit slow);
    if (n > 0) begin
      @(negedge clk);
      if (slow) slowTick = 1'b1; else fastTick = 1'b1;
      repeat (n) @(negedge clk);
      fastTick = 1'b0; slowTick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 irq enable", v, 0);
    rd(8'h08, v); chk("R1 pending", v, 0);
    rd(regA(1, 0), v); chk("R1 ctrl1", v, 0);
    rd(regA(6, 3), v); chk("R1 cmp6", v, 0);
    chk("R1 irqOut", irqOut, 0);

    // R4/R3 free-run counting, clear bit readback, freeze
    wr(regA(3, 0), 32'h33);
    ticks(10, 0);
    rd(regA(3, 2), v); chk("R4 count after 10 ticks", v, 10);
    rd(regA(3, 0), v); chk("R3 ctrl readback clear bit 0", v, 32'h31);
    wr(regA(3, 0), 32'h30);
    ticks(5, 0);
    rd(regA(3, 2), v); chk("R4 disabled holds count", v, 10);

    // R8 wrap and no event on match
    wr(regA(3, 3), 32'hFFFF_FFFF);
    wr(regA(3, 2), 32'hFFFF_FFFE);
    wr(regA(3, 0), 32'h31);
    ticks(3, 0);
    rd(regA(3, 2), v); chk("R8 wrap", v, 1);
    rd(8'h08, v); chk("R8 free-run no pending", v[2], 0);
    wr(regA(3, 0), 32'h30);

    // R6 one-shot, R10 irq, R9 ack masking
    wr(8'h00, 32'h01);
    wr(regA(1, 3), 5);
    wr(regA(1, 0), 32'h03);
    ticks(8, 0);
    rd(regA(1, 2), v); chk("R6 one-shot count", v, 5);
    rd(regA(1, 0), v); chk("R6 enable self-cleared", v, 0);
    rd(8'h08, v); chk("R6 pending set", v, 32'h01);
    chk("R10 irq asserted", irqOut, 1);
    wr(8'h08, 32'h3E);
    rd(8'h08, v); chk("R9 zero bits no effect", v, 32'h01);
    wr(8'h08, 32'h01);
    rd(8'h08, v); chk("R9 ack clears", v, 0);
    chk("R10 irq low after ack", irqOut, 0);

    // R7 repeat, R10 enable masking
    wr(regA(2, 3), 4);
    wr(regA(2, 0), 32'h13);
    ticks(10, 0);
    wr(regA(2, 0), 32'h10);
    rd(regA(2, 2), v); chk("R7 repeat count", v, 2);
    rd(8'h08, v); chk("R7 repeat pending", v, 32'h02);
    chk("R10 masked irq", irqOut, 0);
    wr(8'h00, 32'h03);
    chk("R10 enabled irq", irqOut, 1);
    wr(8'h08, 32'h3F);
    chk("R9 ack all", irqOut, 0);

    // R5 divide by two and phase reset on clear
    wr(regA(4, 1), 32'h01);
    wr(regA(4, 0), 32'h33);
    ticks(9, 0);
    rd(regA(4, 2), v); chk("R5 divide by 2", v, 4);
    wr(regA(4, 0), 32'h33);
    ticks(1, 0);
    rd(regA(4, 2), v); chk("R3 phase reset on clear", v, 0);
    ticks(1, 0);
    rd(regA(4, 2), v); chk("R5 second tick advances", v, 1);
    wr(regA(4, 0), 32'h30);

    // R5 slow source selection
    wr(regA(5, 1), 32'h10);
    wr(regA(5, 0), 32'h33);
    ticks(6, 0);
    rd(regA(5, 2), v); chk("R5 fast ignored on slow source", v, 0);
    ticks(6, 1);
    rd(regA(5, 2), v); chk("R5 slow ticks", v, 6);
    wr(regA(5, 0), 32'h30);

    // R2 address map readback
    wr(regA(6, 3), 32'hA5A5_1234);
    wr(regA(6, 1), 32'h11);
    rd(regA(6, 3), v); chk("R2 cmp6 readback", v, 32'hA5A5_1234);
    rd(regA(6, 1), v); chk("R2 clk6 readback", v, 32'h11);
    rd(8'h00, v); chk("R2 irq enable readback", v, 32'h03);

    // R9 set wins over simultaneous ack
    wr(regA(1, 3), 3);
    wr(regA(1, 0), 32'h03);
    ticks(2, 0);
    @(negedge clk);
    fastTick = 1'b1; busAddr = 8'h08; busWdata = 32'h01; busWr = 1'b1;
    @(negedge clk);
    fastTick = 1'b0; busWr = 1'b0;
    rd(8'h08, v); chk("R9 set beats ack", v[0], 1);
    wr(8'h08, 32'h3F);

    // random programs
    for (int it = 0; it < 24; it++) begin
      int ch = 1 + int'($urandom_range(5, 0));
      int ms = int'($urandom_range(2, 0));
      int mode = (ms == 2) ? 3 : ms;
      int dv = int'($urandom_range(1, 0));
      int cmp = 1 + int'($urandom_range(19, 0));
      int n = int'($urandom_range(40, 0));
      wr(regA(ch, 1), 32'(dv));
      wr(regA(ch, 3), 32'(cmp));
      wr(8'h08, 32'h3F);
      wr(regA(ch, 0), 32'((mode << 4) | 3));
      ticks(n, 0);
      rd(regA(ch, 2), v);
      chk($sformatf("R4 R6 R7 random count ch%0d mode%0d", ch, mode), v, expCount(mode, dv, cmp, n));
      rd(8'h08, v);
      chk($sformatf("R9 random pending ch%0d mode%0d", ch, mode), 32'(v[ch-1]), 32'(expPend(mode, dv, cmp, n)));
      wr(regA(ch, 0), 32'h30);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule